// File: doc/BRIEF.md
# Power-Fail Supervisor and Write Guard

This block supervises a battery-backed static memory from the digital side. Two external comparators report, as plain logic levels, whether the main supply is above the write-protect trip level and whether it is above the lower switchover level. From the trip-level indication the supervisor derives an open-drain style reset request for the host processor and a write-protect state. While write protection is active, it blocks every memory access request. A one-time latch arms the backup source on the first valid power-up. A steering output tells the power switch when the backup source must feed the memory.

After the supply becomes valid, two intervals are counted in ticks of a prescaler of about one millisecond. The recovery interval ends write protection. The longer hold interval releases the reset request, so the processor never runs while memory writes are still blocked. Any supply failure returns the block to its fail state and cancels the count in progress. The next valid supply starts both intervals again from zero. Both comparator inputs pass through synchronizer stages before use.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rst_n` is low and after its release with the supply input low, `rst_pull_o`=1, `wp_o`=1, `backup_en_o`=0, `feed_backup_o`=0, `ce_mem_n_o`=1, `we_mem_n_o`=1 and `dq_oe_o`=0.
- R2: If `supply_ok_i` goes low at any time, `rst_pull_o` and `wp_o` are both 1 after the third rising clock edge. This latency uses the default two synchronizer stages.
- R3: While `wp_o` is 1, `ce_mem_n_o` and `we_mem_n_o` are forced to 1 and `dq_oe_o` is forced to 0 for every combination of request inputs.
- R4: After `supply_ok_i` rises and stays high, `wp_o` goes to 0 exactly 3 + REC_TICKS*CLKS_PER_TICK rising edges later.
- R5: After `supply_ok_i` rises and stays high, `rst_pull_o` goes to 0 exactly 3 + HOLD_TICKS*CLKS_PER_TICK rising edges later.
- R6: `rst_pull_o` is never 0 while `wp_o` is 1. This assumes REC_TICKS <= HOLD_TICKS.
- R7: A supply failure during the hold interval discards the partial count. After the supply is valid again, the R4 and R5 delays are measured from the new rise.
- R8: `backup_en_o` is 0 until the third rising edge after `supply_ok_i` first rises. From then on it stays 1 through all later supply failures, until `rst_n` is low.
- R9: `feed_backup_o` is 1 exactly when `backup_en_o` is 1 and the synchronized `above_switch_i` is 0. The synchronized value follows the input two rising edges later.
- R10: While `wp_o` is 0, `ce_mem_n_o` equals `ce_req_n_i`, `we_mem_n_o` equals `we_req_n_i`, and `dq_oe_o` is 1 only when `ce_req_n_i`=0, `oe_req_n_i`=0 and `we_req_n_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok_i | input | 1 | Comparator: supply above write-protect trip level |
| above_switch_i | input | 1 | Comparator: supply above backup switchover level |
| ce_req_n_i | input | 1 | Requested chip enable, active low |
| we_req_n_i | input | 1 | Requested write enable, active low |
| oe_req_n_i | input | 1 | Requested output enable, active low |
| rst_pull_o | output | 1 | 1 = pull the open-drain reset line low |
| wp_o | output | 1 | Write protection active |
| ce_mem_n_o | output | 1 | Gated chip enable to the memory, active low |
| we_mem_n_o | output | 1 | Gated write enable to the memory, active low |
| dq_oe_o | output | 1 | Data pad drive enable (0 = high impedance) |
| backup_en_o | output | 1 | Backup source armed (one-time latch) |
| feed_backup_o | output | 1 | 1 = backup source feeds the memory |

## Verification
The assertions check several invariants on every cycle. Protection must override the access requests, and reset must cover write protection. The backup latch must never clear, the steering output must stay inside the armed state, and a sustained supply failure must reach reset within its latency. Only the bench's scenarios can show the exact recovery and hold delays counted in prescaler ticks, and the restart of a partial hold count after a mid-interval failure. The same holds for the first-rise timing of the backup latch and for the transparent access path once protection ends.

// File: rtl/pfs_pkg.sv
// Package: shared types for the power-fail supervisor.
// Assumes nothing beyond IEEE 1800-2017.
package pfs_pkg;

    // Supervisor sequencing states
    typedef enum logic [1:0] {
        PS_FAIL = 2'd0,   // supply below trip level
        PS_HOLD = 2'd1,   // supply valid, counting recovery/hold
        PS_RUN  = 2'd2    // normal operation
    } pwr_state_e;

endpackage

// File: rtl/pfs_sync.sv
// Module: multi-stage synchronizer for asynchronous comparator levels.
// Assumes: inputs are quasi-static levels; reset value of every stage is 0.
module pfs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw asynchronous level
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            // Pass the level along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pfs_prescale.sv
// Module: tick prescaler; one-cycle tick every CLKS_PER_TICK enabled clocks.
// Assumes: counter restarts from zero whenever en_i is low.
module pfs_prescale #(
    parameter int CLKS_PER_TICK = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);

    localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_TICK - 1);

    logic [PW-1:0] div_q;

    // Divide the clock while enabled, hold at zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)  div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
    end

    assign tick_o = en_i && (div_q == LAST);

endmodule

// File: rtl/pfs_seq.sv
// Module: supply sequencer. Tracks fail/hold/run, counts ticks after the
// supply becomes valid, derives write protection and reset, and keeps the
// one-time backup-arm latch.
// Assumes: ok_i is synchronized; REC_TICKS <= HOLD_TICKS; HOLD_TICKS >= 1.
module pfs_seq
    import pfs_pkg::*;
#(
    parameter int REC_TICKS  = 125,
    parameter int HOLD_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_i,
    input  logic tick_i,
    output logic count_en_o,
    output logic wp_o,
    output logic rst_pull_o,
    output logic backup_en_o
);

    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] REC_END   = CW'(REC_TICKS);

    pwr_state_e    state_q;
    logic [CW-1:0] ticks_q;
    logic          armed_q;

    // Sequence states and count ticks since the supply became valid
    always_ff @(posedge clk) begin
        if (!rst_n || !ok_i) begin
            state_q <= PS_FAIL;
            ticks_q <= '0;
        end else begin
            unique case (state_q)
                PS_FAIL: begin
                    state_q <= PS_HOLD;
                    ticks_q <= '0;
                end
                PS_HOLD: begin
                    if (tick_i) begin
                        ticks_q <= ticks_q + 1'b1;
                        if (ticks_q == HOLD_LAST) state_q <= PS_RUN;
                    end
                end
                default: state_q <= PS_RUN;
            endcase
        end
    end

    // Arm the backup source on the first valid supply; never disarm
    always_ff @(posedge clk) begin
        if (!rst_n)    armed_q <= 1'b0;
        else if (ok_i) armed_q <= 1'b1;
    end

    // Derive outputs from the sequencing state
    always_comb begin
        count_en_o  = (state_q == PS_HOLD);
        wp_o        = (state_q == PS_FAIL) ||
                      ((state_q == PS_HOLD) && (ticks_q < REC_END));
        rst_pull_o  = (state_q != PS_RUN);
        backup_en_o = armed_q;
    end

endmodule

// File: rtl/pfs_gate.sv
// Module: access gate. Forces memory strobes inactive and data pads to
// high impedance while protection is active; transparent otherwise.
// Assumes: all strobes active low; purely combinational.
module pfs_gate (
    input  logic wp_i,
    input  logic ce_req_n_i,
    input  logic we_req_n_i,
    input  logic oe_req_n_i,
    output logic ce_mem_n_o,
    output logic we_mem_n_o,
    output logic dq_oe_o
);

    // Block or pass the requested access
    always_comb begin
        if (wp_i) begin
            ce_mem_n_o = 1'b1;
            we_mem_n_o = 1'b1;
            dq_oe_o    = 1'b0;
        end else begin
            ce_mem_n_o = ce_req_n_i;
            we_mem_n_o = we_req_n_i;
            dq_oe_o    = !ce_req_n_i && !oe_req_n_i && we_req_n_i;
        end
    end

endmodule

// File: rtl/pfs_supervisor.sv
// Module: top of the power-fail supervisor and write guard.
// Assumes: comparator levels are asynchronous; CLKS_PER_TICK gives ~1 ms;
// REC_TICKS <= HOLD_TICKS so reset always outlasts write protection.
module pfs_supervisor #(
    parameter int CLKS_PER_TICK = 50000,
    parameter int REC_TICKS     = 125,
    parameter int HOLD_TICKS    = 200,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic above_switch_i,
    input  logic ce_req_n_i,
    input  logic we_req_n_i,
    input  logic oe_req_n_i,
    output logic rst_pull_o,
    output logic wp_o,
    output logic ce_mem_n_o,
    output logic we_mem_n_o,
    output logic dq_oe_o,
    output logic backup_en_o,
    output logic feed_backup_o
);

    logic [1:0] lvl_s;
    logic       ok_s, sw_s;
    logic       count_en, tick, wp;

    pfs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({above_switch_i, supply_ok_i}),
        .q_o   (lvl_s)
    );

    assign ok_s = lvl_s[0];
    assign sw_s = lvl_s[1];

    pfs_prescale #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (count_en),
        .tick_o (tick)
    );

    pfs_seq #(.REC_TICKS(REC_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ok_i        (ok_s),
        .tick_i      (tick),
        .count_en_o  (count_en),
        .wp_o        (wp),
        .rst_pull_o  (rst_pull_o),
        .backup_en_o (backup_en_o)
    );

    pfs_gate u_gate (
        .wp_i       (wp),
        .ce_req_n_i (ce_req_n_i),
        .we_req_n_i (we_req_n_i),
        .oe_req_n_i (oe_req_n_i),
        .ce_mem_n_o (ce_mem_n_o),
        .we_mem_n_o (we_mem_n_o),
        .dq_oe_o    (dq_oe_o)
    );

    // Steer the memory supply: backup only when armed and below switchover
    always_comb begin
        feed_backup_o = backup_en_o && !sw_s;
        wp_o          = wp;
    end

endmodule

// File: rtl/pfs_supervisor_chk.sv
// Module: property checker for pfs_supervisor, attached by bind.
// Assumes: default two synchronizer stages for the failure latency check.
module pfs_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok_i,
    input logic rst_pull_o,
    input logic wp_o,
    input logic ce_mem_n_o,
    input logic we_mem_n_o,
    input logic dq_oe_o,
    input logic backup_en_o,
    input logic feed_backup_o
);

    // R3
    wp_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_o |-> (ce_mem_n_o && we_mem_n_o && !dq_oe_o));

    // R6
    rst_covers_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pull_o |-> !wp_o);

    // R8
    backup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_en_o |=> backup_en_o);

    // R9
    feed_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_backup_o |-> backup_en_o);

    // R2
    fail_reaches_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok_i && $past(!supply_ok_i) && $past(!supply_ok_i, 2))
        |=> (rst_pull_o && wp_o));

endmodule

bind pfs_supervisor pfs_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_ok_i   (supply_ok_i),
    .rst_pull_o    (rst_pull_o),
    .wp_o          (wp_o),
    .ce_mem_n_o    (ce_mem_n_o),
    .we_mem_n_o    (we_mem_n_o),
    .dq_oe_o       (dq_oe_o),
    .backup_en_o   (backup_en_o),
    .feed_backup_o (feed_backup_o)
);

// File: tb/tb_pfs_supervisor.sv
// Bench for pfs_supervisor: table-driven access checks plus directed
// sequencing, restart and latch scenarios.
module tb_pfs_supervisor;

    localparam int CPT  = 4;
    localparam int REC  = 5;
    localparam int HOLD = 8;

    // {ce_req_n, we_req_n, oe_req_n, exp ce_mem_n, exp we_mem_n, exp dq_oe}
    localparam logic [5:0] VEC [8] = '{
        6'b000_000, 6'b001_000, 6'b010_011, 6'b011_010,
        6'b100_100, 6'b101_100, 6'b110_110, 6'b111_110
    };

    logic clk = 1'b0;
    logic rst_n, supply_ok, above_sw, ce_n, we_n, oe_n;
    logic rst_pull, wp, ce_mem_n, we_mem_n, dq_oe, backup_en, feed_backup;
    int   n_run = 0;
    int   n_fail = 0;

    always #10 clk = ~clk;

    pfs_supervisor #(.CLKS_PER_TICK(CPT), .REC_TICKS(REC), .HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .above_switch_i(above_sw),
        .ce_req_n_i(ce_n), .we_req_n_i(we_n), .oe_req_n_i(oe_n),
        .rst_pull_o(rst_pull), .wp_o(wp), .ce_mem_n_o(ce_mem_n), .we_mem_n_o(we_mem_n),
        .dq_oe_o(dq_oe), .backup_en_o(backup_en), .feed_backup_o(feed_backup)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic walk(input string req, input logic prot);
        for (int i = 0; i < 8; i++) begin
            {ce_n, we_n, oe_n} = VEC[i][5:3];
            edges(1);
            chk(req, {ce_mem_n, we_mem_n, dq_oe}, prot ? 3'b110 : VEC[i][2:0]);
        end
        {ce_n, we_n, oe_n} = 3'b111;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b0; above_sw = 1'b0;
        {ce_n, we_n, oe_n} = 3'b111;
        edges(3);
        // R1 during reset
        chk("R1", {rst_pull, wp, backup_en}, 3'b110);
        rst_n = 1'b1;
        edges(4);
        chk("R1", {rst_pull, wp, backup_en}, 3'b110);
        chk("R1", {ce_mem_n, we_mem_n, dq_oe}, 3'b110);
        chk("R1", {2'b00, feed_backup}, 3'b000);
        // R9: below switchover but not armed
        chk("R9", {2'b00, feed_backup}, 3'b000);
        // R3: requests blocked while protected
        walk("R3", 1'b1);

        // First power-up
        supply_ok = 1'b1; above_sw = 1'b1;
        edges(2);
        chk("R8", {2'b00, backup_en}, 3'b000);
        edges(1);
        chk("R8", {2'b00, backup_en}, 3'b001);
        edges(REC * CPT - 1);            // 2 + REC*CPT edges
        chk("R4", {1'b0, rst_pull, wp}, 3'b011);
        edges(1);                        // 3 + REC*CPT edges
        chk("R4", {1'b0, rst_pull, wp}, 3'b010);
        chk("R6", {1'b0, rst_pull, wp}, 3'b010);
        edges((HOLD - REC) * CPT - 1);   // 2 + HOLD*CPT edges
        chk("R5", {1'b0, rst_pull, wp}, 3'b010);
        edges(1);                        // 3 + HOLD*CPT edges
        chk("R5", {1'b0, rst_pull, wp}, 3'b000);
        // R10: transparent access once running
        walk("R10", 1'b0);

        // Supply failure
        supply_ok = 1'b0;
        edges(2);
        chk("R2", {1'b0, rst_pull, wp}, 3'b000);
        edges(1);
        chk("R2", {1'b0, rst_pull, wp}, 3'b011);
        chk("R8", {2'b00, backup_en}, 3'b001);
        walk("R3", 1'b1);

        // R9: steering follows switchover level once armed
        above_sw = 1'b0;
        edges(1);
        chk("R9", {2'b00, feed_backup}, 3'b000);
        edges(1);
        chk("R9", {2'b00, feed_backup}, 3'b001);
        above_sw = 1'b1;
        edges(2);
        chk("R9", {2'b00, feed_backup}, 3'b000);

        // R7: failure mid-hold restarts the count
        supply_ok = 1'b1;
        edges(3 + 3 * CPT);
        chk("R7", {1'b0, rst_pull, wp}, 3'b011);
        supply_ok = 1'b0;
        edges(5);
        chk("R7", {1'b0, rst_pull, wp}, 3'b011);
        supply_ok = 1'b1;
        edges(2 + REC * CPT);
        chk("R7", {1'b0, rst_pull, wp}, 3'b011);
        edges(1);
        chk("R7", {1'b0, rst_pull, wp}, 3'b010);
        edges((HOLD - REC) * CPT - 1);
        chk("R7", {1'b0, rst_pull, wp}, 3'b010);
        edges(1);
        chk("R7", {1'b0, rst_pull, wp}, 3'b000);

        // R8: reset clears the latch again
        rst_n = 1'b0; supply_ok = 1'b0; above_sw = 1'b0;
        edges(2);
        rst_n = 1'b1;
        edges(3);
        chk("R8", {rst_pull, wp, backup_en}, 3'b110);
        chk("R9", {2'b00, feed_backup}, 3'b000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule